// File: doc/BRIEF.md
# Programmable memory strobe timing generator

This block drives one memory read or write cycle at a time, as the bus master. The width of the active-low read or write strobe and the gap that follows it are counted on the block's own clock. The system bus clock plays no part in this timing. At the nominal 20 MHz base clock every phase is a whole number of 50 ns steps. A speed code picks the pulse and recovery lengths from a small fixed table. One reserved code takes a pulse/recovery pair supplied on separate inputs, which lets any legal pulse go with any legal recovery.

A start request launches a cycle in the chosen direction. During the last clock of the pulse, the memory side may hold the ready line low to stretch the pulse one clock at a time. On reads, a latch strobe marks the clock in which data must be captured, the last one before the read strobe goes high. A one-clock done pulse marks the last recovery clock. A start request seen at the end of that clock begins the next cycle with no idle gap.

Top module: `strobe_timing_gen`

## Requirements
- R1: While reset is asserted and after it is released, both strobes are high (negated), and the latch strobe and done are low.
- R2: A start request sampled at a clock edge while idle drives the strobe chosen by `write_sel` low from that edge (1 = write strobe, 0 = read strobe). The other strobe stays high, and the two strobes are never low together.
- R3: Speed codes 0, 1, 2, 3 and 4 give pulse/recovery lengths, in base clocks, of 5/3, 3/3, 2/3, 2/2 and 4/3.
- R4: Speed code 255 takes its timing from `custom_pulse` and `custom_recovery`, both in base clocks. The pulse is clamped to the range 2..9 and the recovery to a minimum of 2. For example 9/3 gives a 450 ns pulse and 150 ns recovery.
- R5: Any speed code other than 0 to 4 and 255 uses the code-0 timing of 5/3.
- R6: `mem_ready` is sampled only during the final pulse clock. Each clock it is low there adds one clock to the pulse. At any other time it has no effect, and the recovery phase is never lengthened.
- R7: `rd_latch` is high during the final pulse clock of a read cycle, in the clock where `mem_ready` is high, so the read strobe goes high at the next edge. It is never high in a write cycle.
- R8: `cycle_done` is high for exactly the last recovery clock. A start request present in that clock launches the next cycle at the edge that ends it. Start requests at any earlier point of a cycle are ignored.
- R9: Speed code, custom pair and direction are captured when a start is accepted. Changing them during a cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base timing clock (one period is one timing step) |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_code | input | 8 | Timing selector |
| custom_pulse | input | 4 | Pulse length in clocks for the custom code |
| custom_recovery | input | 4 | Recovery length in clocks for the custom code |
| write_sel | input | 1 | 1 = write cycle, 0 = read cycle |
| start | input | 1 | Cycle start request |
| mem_ready | input | 1 | Ready from memory; low stretches the pulse |
| mem_rd_n | output | 1 | Active-low memory read strobe |
| mem_wr_n | output | 1 | Active-low memory write strobe |
| rd_latch | output | 1 | Read data capture strobe |
| cycle_done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The strobes come from registered state, so they change at the edge that samples the start or ends a phase. `rd_latch` follows `mem_ready` within the same clock, with no register in between. `cycle_done` appears in the clock that is the last of the recovery. The bench applies every input just after a falling edge and waits one nanosecond before comparing all four outputs with a behavioural model. The model then moves forward by one rising edge, so each result is checked in the exact clock it is due.

// File: rtl/stg_pkg.sv
package stg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PULSE = 2'd1,
        PH_REC   = 2'd2
    } phase_e;

    localparam int unsigned TABLE_N = 5;
    // base-clock counts indexed by speed code
    localparam int unsigned TBL_PULSE [TABLE_N] = '{5, 3, 2, 2, 4};
    localparam int unsigned TBL_REC   [TABLE_N] = '{3, 3, 3, 2, 3};
    localparam int unsigned FALLBACK_CODE = 0;

endpackage

// File: rtl/stg_rate_decode.sv
module stg_rate_decode
    import stg_pkg::*;
#(
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned MIN_CLK     = 2,
    parameter int unsigned MAX_PULSE   = 9,
    parameter int unsigned CUSTOM_CODE = 255
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CNT_W-1:0]  cust_pulse,
    input  logic [CNT_W-1:0]  cust_rec,
    output logic [CNT_W-1:0]  pulse_clk,
    output logic [CNT_W-1:0]  rec_clk
);

    localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_CLK);
    localparam logic [CNT_W-1:0] MAXP_C = CNT_W'(MAX_PULSE);

    logic [CNT_W-1:0] cp_clamped;
    logic [CNT_W-1:0] cr_clamped;

    always_comb begin
        if (cust_pulse < MIN_C)
            cp_clamped = MIN_C;
        else if (cust_pulse > MAXP_C)
            cp_clamped = MAXP_C;
        else
            cp_clamped = cust_pulse;
        cr_clamped = (cust_rec < MIN_C) ? MIN_C : cust_rec;
    end

    always_comb begin
        pulse_clk = CNT_W'(TBL_PULSE[FALLBACK_CODE]);
        rec_clk   = CNT_W'(TBL_REC[FALLBACK_CODE]);
        for (int i = 0; i < TABLE_N; i++) begin
            if (code == CODE_W'(i)) begin
                pulse_clk = CNT_W'(TBL_PULSE[i]);
                rec_clk   = CNT_W'(TBL_REC[i]);
            end
        end
        if (code == CODE_W'(CUSTOM_CODE)) begin
            pulse_clk = cp_clamped;
            rec_clk   = cr_clamped;
        end
    end

endmodule

// File: rtl/stg_sequencer.sv
module stg_sequencer
    import stg_pkg::*;
#(
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned MIN_CLK   = 2,
    parameter int unsigned MAX_PULSE = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_write,
    input  logic             rdy,
    input  logic [CNT_W-1:0] pulse_clk,
    input  logic [CNT_W-1:0] rec_clk,
    output logic             rd_n,
    output logic             wr_n,
    output logic             latch_stb,
    output logic             done
);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rec;
        logic             wr;
    } seq_t;

    seq_t st_d, st_q;
    logic last_clk;
    logic accept;
    logic done_c;
    logic latch_c;

    always_comb begin
        st_d     = st_q;
        last_clk = (st_q.cnt == '0);
        accept   = 1'b0;
        done_c   = 1'b0;
        latch_c  = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                accept = start;
            end
            PH_PULSE: begin
                if (last_clk) begin
                    if (rdy) begin
                        latch_c  = !st_q.wr;
                        st_d.ph  = PH_REC;
                        st_d.cnt = st_q.rec - 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_REC: begin
                if (last_clk) begin
                    done_c  = 1'b1;
                    st_d.ph = PH_IDLE;
                    accept  = start;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
        if (accept) begin
            st_d.ph  = PH_PULSE;
            st_d.cnt = pulse_clk - 1'b1;
            st_d.rec = rec_clk;
            st_d.wr  = is_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, rec: '0, wr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_n      = !((st_q.ph == PH_PULSE) && !st_q.wr);
    assign wr_n      = !((st_q.ph == PH_PULSE) &&  st_q.wr);
    assign latch_stb = latch_c;
    assign done      = done_c;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R2

    AST_TIMING_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && start) |->
        (pulse_clk >= CNT_W'(MIN_CLK) && pulse_clk <= CNT_W'(MAX_PULSE)
         && rec_clk >= CNT_W'(MIN_CLK))); // R4

    AST_LATCH_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |-> (!rd_n && wr_n)); // R7

    AST_LATCH_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> rd_n); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_IN_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_n && wr_n)); // R8

    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && $past(rd_n)) |=> !rd_n); // R4

    AST_REC_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |=> (rd_n && wr_n)); // R4

endmodule

// File: rtl/strobe_timing_gen.sv
module strobe_timing_gen
    import stg_pkg::*;
#(
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned MIN_CLK     = 2,
    parameter int unsigned MAX_PULSE   = 9,
    parameter int unsigned CUSTOM_CODE = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] speed_code,
    input  logic [CNT_W-1:0]  custom_pulse,
    input  logic [CNT_W-1:0]  custom_recovery,
    input  logic              write_sel,
    input  logic              start,
    input  logic              mem_ready,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              rd_latch,
    output logic              cycle_done
);

    logic [CNT_W-1:0] pulse_clk;
    logic [CNT_W-1:0] rec_clk;

    stg_rate_decode #(
        .CODE_W     (CODE_W),
        .CNT_W      (CNT_W),
        .MIN_CLK    (MIN_CLK),
        .MAX_PULSE  (MAX_PULSE),
        .CUSTOM_CODE(CUSTOM_CODE)
    ) u_decode (
        .code      (speed_code),
        .cust_pulse(custom_pulse),
        .cust_rec  (custom_recovery),
        .pulse_clk (pulse_clk),
        .rec_clk   (rec_clk)
    );

    stg_sequencer #(
        .CNT_W    (CNT_W),
        .MIN_CLK  (MIN_CLK),
        .MAX_PULSE(MAX_PULSE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_write (write_sel),
        .rdy      (mem_ready),
        .pulse_clk(pulse_clk),
        .rec_clk  (rec_clk),
        .rd_n     (mem_rd_n),
        .wr_n     (mem_wr_n),
        .latch_stb(rd_latch),
        .done     (cycle_done)
    );

endmodule

// File: tb/sim_strobe_timing_gen.sv
module sim_strobe_timing_gen;

    localparam int CLK_PERIOD = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] speed_code = 8'd0;
    logic [3:0] custom_pulse = 4'd0;
    logic [3:0] custom_recovery = 4'd0;
    logic       write_sel = 1'b0;
    logic       start = 1'b0;
    logic       mem_ready = 1'b1;
    logic       mem_rd_n, mem_wr_n, rd_latch, cycle_done;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";

    // behavioural model: phase 0 idle, 1 pulse, 2 recovery
    int m_ph = 0, m_el = 0, m_p = 0, m_r = 0;
    bit m_wr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .speed_code(speed_code),
        .custom_pulse(custom_pulse), .custom_recovery(custom_recovery),
        .write_sel(write_sel), .start(start), .mem_ready(mem_ready),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .rd_latch(rd_latch), .cycle_done(cycle_done)
    );

    task automatic exp_timing(input int code, input int cp, input int cr,
                              output int p, output int r);
        case (code)
            0: begin p = 5; r = 3; end
            1: begin p = 3; r = 3; end
            2: begin p = 2; r = 3; end
            3: begin p = 2; r = 2; end
            4: begin p = 4; r = 3; end
            255: begin
                p = (cp < 2) ? 2 : ((cp > 9) ? 9 : cp);
                r = (cr < 2) ? 2 : cr;
            end
            default: begin p = 5; r = 3; end
        endcase
    endtask

    // inputs are already set; compare, then advance the model by one edge
    task automatic tick();
        logic [3:0] exp_v, act_v;
        bit in_p, fin, dn, acc;
        #1;
        in_p = (m_ph == 1);
        fin  = in_p && (m_el >= m_p - 1);
        dn   = (m_ph == 2) && (m_el == m_r - 1);
        exp_v = {!(in_p && !m_wr), !(in_p && m_wr),
                 (fin && !m_wr && mem_ready && rst_n), dn};
        act_v = {mem_rd_n, mem_wr_n, rd_latch, cycle_done};
        checks++;
        if (act_v !== exp_v) begin
            failures++;
            $display("FAIL %s t=%0t rd_n/wr_n/latch/done actual=%b expected=%b",
                     cur_tag, $time, act_v, exp_v);
        end
        if (rst_n) begin
            acc = start && (m_ph == 0 || dn);
            if (m_ph == 1) begin
                if (fin && mem_ready) begin m_ph = 2; m_el = 0; end
                else m_el++;
            end else if (m_ph == 2) begin
                if (dn) m_ph = 0; else m_el++;
            end
            if (acc) begin
                m_ph = 1; m_el = 0; m_wr = write_sel;
                exp_timing(int'(speed_code), int'(custom_pulse),
                           int'(custom_recovery), m_p, m_r);
            end
        end
        @(negedge clk);
    endtask

    task automatic run_cycle(input int code, input bit wr,
                             input int cp, input int cr);
        speed_code = 8'(code); write_sel = wr;
        custom_pulse = 4'(cp); custom_recovery = 4'(cr);
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int n = 0; n < 40 && m_ph != 0; n++) tick();
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        cur_tag = "R1";
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) tick();

        cur_tag = "R3";
        for (int c = 0; c < 5; c++) begin
            run_cycle(c, 1'b0, 0, 0);
            run_cycle(c, 1'b1, 0, 0);
        end

        cur_tag = "R2";
        run_cycle(1, 1'b1, 0, 0);

        cur_tag = "R5";
        run_cycle(7, 1'b0, 3, 3);
        run_cycle(128, 1'b1, 2, 2);
        run_cycle(254, 1'b0, 9, 9);

        cur_tag = "R4";
        run_cycle(255, 1'b0, 9, 3);
        run_cycle(255, 1'b1, 4, 2);
        run_cycle(255, 1'b0, 15, 0);
        run_cycle(255, 1'b0, 0, 5);
        run_cycle(255, 1'b1, 1, 1);

        // R6: ready low in final pulse clock stretches; elsewhere ignored
        cur_tag = "R6";
        speed_code = 8'd2; write_sel = 1'b0; start = 1'b1;
        tick();
        start = 1'b0;
        mem_ready = 1'b0;
        for (int i = 0; i < 4; i++) tick();
        mem_ready = 1'b1;
        tick();
        mem_ready = 1'b0;
        for (int i = 0; i < 4; i++) tick();
        mem_ready = 1'b1;
        tick();
        speed_code = 8'd0; write_sel = 1'b1; start = 1'b1;
        mem_ready = 1'b0;
        tick();
        start = 1'b0;
        for (int i = 0; i < 2; i++) tick();
        mem_ready = 1'b1;
        for (int n = 0; n < 20 && m_ph != 0; n++) tick();
        tick();

        // R7: read latch lands in the clock before the read strobe rises
        cur_tag = "R7";
        run_cycle(3, 1'b0, 0, 0);
        run_cycle(3, 1'b1, 0, 0);

        // R8: start held throughout; early requests ignored, back-to-back
        cur_tag = "R8";
        speed_code = 8'd3; write_sel = 1'b0; start = 1'b1;
        for (int i = 0; i < 13; i++) tick();
        start = 1'b0;
        for (int n = 0; n < 20 && m_ph != 0; n++) tick();
        tick();

        // R9: inputs changed mid-cycle do not alter the running cycle
        cur_tag = "R9";
        speed_code = 8'd255; custom_pulse = 4'd6; custom_recovery = 4'd4;
        write_sel = 1'b0; start = 1'b1;
        tick();
        start = 1'b0;
        speed_code = 8'd3; write_sel = 1'b1; custom_pulse = 4'd2;
        custom_recovery = 4'd2;
        for (int n = 0; n < 20 && m_ph != 0; n++) tick();
        tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule